// File: doc/BRIEF.md
# Paged Real-Time Clock Register Window

This block is the byte-wide host side of a real-time clock. A host reaches every piece of clock state through one 32-byte address window. A page bit that software sets selects which of two 32-byte pages the window shows. Page 0 holds the control, interrupt and alarm-enable registers, a read-only view of the live counter bytes, the alarm compare bytes, the time-save bytes and some spare RAM. Page 1 is almost entirely general-purpose RAM. The counter chain sits outside the block and feeds its bytes in on a flat vector.

The block compares the alarm bytes with the live counters under a per-byte enable mask. It holds three interrupt flags: periodic tick, alarm match and power fail. Each flag has a mask bit, and one active-high interrupt output serves all three. A power-fail input locks the host out for as long as it is high. On its rising edge, when the save option is enabled, the block copies the counters into the time-save bytes.

A host access starts on the first clock in which `cs` is high after a clock in which it was low. Writes take effect on that edge. Read data appears on `rdata` one clock later and stays there until the next access, so a counter value read back cannot change in the middle of a bus cycle.

Top module: `rtc_paged_regs`

## Requirements
- R1: After reset, the control register is 0, which selects page 0 with saving off. All interrupt flags and masks are 0, `irq` is low and `rdata` is 0x00.
- R2: Offset 0x00 is the control register on both pages. Bit 0 selects the page (0 or 1) and bit 1 enables time saving. Both bits read back as written, and bits 7:2 read as 0.
- R3: The page 0 map is as follows. 0x01 is interrupt status, 0x02 is the interrupt mask and 0x03 is the alarm-enable mask, with bit i serving counter byte i. Counter bytes 0..6 are at 0x04-0x0A, alarm bytes 0..6 at 0x0B-0x11, save bytes 0..6 at 0x12-0x18 and general RAM at 0x19-0x1F. On page 1, offsets 0x01-0x1F are general RAM. Every RAM byte reads back what was last written to it, and the two pages are separate storage.
- R4: A read at a counter offset returns the counter byte as it was at the start of the access. That value stays on `rdata` even if the counter changes while `cs` is held high. Writes to counter offsets have no effect.
- R5: An access acts once, on the rising edge of `cs`. Read data is valid from the following clock and holds until the next access.
- R6: While `pwr_fail` is high, host writes have no effect and a read returns 0x00.
- R7: The alarm flag (status bit 1) sets on the clock when a match begins. A match means the alarm-enable mask is nonzero and every enabled alarm byte equals its counter byte. When the mask is zero there is never a match.
- R8: A `tick` pulse sets status bit 0. A rising edge of `pwr_fail` sets status bit 2.
- R9: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. A set arriving on the same clock as a clear wins.
- R10: `irq` is high exactly when some flag is set and its mask bit (same bit position at 0x02) is 1.
- R11: On a rising edge of `pwr_fail` with control bit 1 set, counter bytes 0..6 are copied into save bytes 0..6. With control bit 1 clear, the save bytes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Access select; an access starts on its rising edge |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | 5 | Byte offset within the selected page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| cnt_vec | input | 56 | Live counter bytes, byte i in bits 8i+7:8i |
| tick | input | 1 | Periodic interrupt pulse |
| pwr_fail | input | 1 | Power-fail condition, locks out the host |
| irq | output | 1 | Active-high interrupt request |

## Verification
The checker watches on every cycle that a read under lockout returns zero and that the page bit changes only through an accepted write to offset 0. It also checks that a tick sets its flag, that a flag persists until it is cleared, and that neither a zero interrupt mask nor a zero alarm-enable mask can produce `irq` or a match. The bench scenarios cover what needs a sequence of operations: the address map on both pages, the independence of the two pages, counter values holding during a long access, alarm matching across several enabled bytes, save-on-fail with the option on and off, and set-over-clear priority.

// File: rtl/rtc_bus_pkg.sv
// Package: shared offsets and bit positions of the paged RTC register window.
// Assumes an 8-bit data bus; counter-related offsets are derived in the modules.
package rtc_bus_pkg;
    localparam int OFF_CTRL  = 0;
    localparam int OFF_STAT  = 1;
    localparam int OFF_MASK  = 2;
    localparam int OFF_AEN   = 3;
    localparam int CNT_BASE  = 4;

    localparam int CTRL_PAGE = 0;
    localparam int CTRL_SAVE = 1;

    localparam int NUM_IRQ   = 3;
    localparam int IRQ_TICK  = 0;
    localparam int IRQ_ALARM = 1;
    localparam int IRQ_PFAIL = 2;
endpackage

// File: rtl/rtc_host_port.sv
// Module: rtc_host_port
// Turns the level-style select into single-cycle access strobes and applies the
// power-fail lockout. Assumes cs is synchronous to clk and low for at least one
// clock between accesses.
module rtc_host_port (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic wr,
    input  logic pwr_fail,
    output logic wr_stb,
    output logic rd_stb,
    output logic lock_rd,
    output logic pf_rise
);
    logic cs_q;
    logic pf_q;
    logic start;

    // Remember previous select and power-fail levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            pf_q <= 1'b0;
        end else begin
            cs_q <= cs;
            pf_q <= pwr_fail;
        end
    end

    // Decode accepted and locked-out accesses.
    always_comb begin
        start   = cs && !cs_q;
        wr_stb  = start && wr && !pwr_fail;
        rd_stb  = start && !wr && !pwr_fail;
        lock_rd = start && !wr && pwr_fail;
        pf_rise = pwr_fail && !pf_q;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: rtc_alarm_cmp
// Compares each enabled alarm byte with its counter byte and reports the
// start of a full match. Assumes counters and alarm bytes are stable per clock.
module rtc_alarm_cmp #(
    parameter int NUM_CNT = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CNT*8-1:0]   cnt_vec,
    input  logic [NUM_CNT*8-1:0]   alm_vec,
    input  logic [NUM_CNT-1:0]     aen,
    output logic                   match,
    output logic                   match_rise
);
    logic [NUM_CNT-1:0] byte_ok;
    logic               match_q;

    // One comparator per counter byte; a disabled byte always agrees.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cmp
        assign byte_ok[i] = !aen[i] || (cnt_vec[i*8 +: 8] == alm_vec[i*8 +: 8]);
    end

    // A match needs at least one enabled byte.
    assign match      = (|aen) && (&byte_ok);
    assign match_rise = match && !match_q;

    // Track previous match state so the flag fires once per match.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: rtc_irq_ctrl
// Sticky interrupt flags with write-one-to-clear and per-flag mask.
// Assumes set and clear vectors are single-cycle qualified.
module rtc_irq_ctrl #(
    parameter int NUM_IRQ = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [NUM_IRQ-1:0] flags,
    output logic               irq
);
    // Flags: clear first, then set, so a set in the same clock wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Interrupt output is the OR of unmasked flags.
    assign irq = |(flags & mask);
endmodule

// File: rtl/rtc_regfile.sv
// Module: rtc_regfile
// Control, mask and alarm-enable registers, the two-page byte store and the
// read mux. Assumes strobes are single-cycle and save never coincides with a
// host write (the lockout guarantees it).
module rtc_regfile
    import rtc_bus_pkg::*;
#(
    parameter int NUM_CNT    = 7,
    parameter int PAGE_BYTES = 32,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    input  logic                 lock_rd,
    input  logic                 save_stb,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    input  logic [NUM_CNT*8-1:0] cnt_vec,
    input  logic [NUM_IRQ-1:0]   flags,
    output logic [7:0]           rdata,
    output logic                 page,
    output logic [NUM_IRQ-1:0]   irq_mask,
    output logic [NUM_CNT-1:0]   aen,
    output logic [NUM_CNT*8-1:0] alm_vec,
    output logic [NUM_IRQ-1:0]   clr_vec
);
    localparam int ALM_BASE  = CNT_BASE + NUM_CNT;
    localparam int SAV_BASE  = ALM_BASE + NUM_CNT;
    localparam int RAM_DEPTH = 2 * PAGE_BYTES;
    localparam int IDX_W     = ADDR_W + 1;

    logic [1:0]         ctrl_q;
    logic [7:0]         ram_q [RAM_DEPTH];
    logic [IDX_W-1:0]   idx;
    logic               is_ctrl, is_stat, is_mask, is_aen, is_ram;
    logic [7:0]         rd_val;

    assign page = ctrl_q[CTRL_PAGE];
    assign idx  = {page, addr};

    // Region decode for the current page.
    always_comb begin
        is_ctrl = (addr == ADDR_W'(OFF_CTRL));
        is_stat = !page && (addr == ADDR_W'(OFF_STAT));
        is_mask = !page && (addr == ADDR_W'(OFF_MASK));
        is_aen  = !page && (addr == ADDR_W'(OFF_AEN));
        is_ram  = page ? !is_ctrl : (addr >= ADDR_W'(ALM_BASE));
    end

    // Read mux: registers, live counters, otherwise the byte store.
    always_comb begin
        rd_val = ram_q[idx];
        if (is_ctrl)      rd_val = 8'(ctrl_q);
        else if (is_stat) rd_val = 8'(flags);
        else if (is_mask) rd_val = 8'(irq_mask);
        else if (is_aen)  rd_val = 8'(aen);
        else if (!page) begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (addr == ADDR_W'(CNT_BASE + i)) rd_val = cnt_vec[i*8 +: 8];
            end
        end
    end

    // Write-one-to-clear request to the flag logic.
    assign clr_vec = (wr_stb && is_stat) ? wdata[NUM_IRQ-1:0] : '0;

    // Alarm compare bytes come straight out of the page 0 store.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_alm
        assign alm_vec[i*8 +: 8] = ram_q[ALM_BASE + i];
    end

    // Register and store updates, save-on-fail, and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            irq_mask <= '0;
            aen      <= '0;
            rdata    <= '0;
            for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
        end else begin
            if (wr_stb) begin
                if (is_ctrl) ctrl_q   <= wdata[1:0];
                if (is_mask) irq_mask <= wdata[NUM_IRQ-1:0];
                if (is_aen)  aen      <= wdata[NUM_CNT-1:0];
                if (is_ram)  ram_q[idx] <= wdata;
            end
            if (save_stb && ctrl_q[CTRL_SAVE]) begin
                for (int i = 0; i < NUM_CNT; i++)
                    ram_q[SAV_BASE + i] <= cnt_vec[i*8 +: 8];
            end
            if (rd_stb)       rdata <= rd_val;
            else if (lock_rd) rdata <= '0;
        end
    end
endmodule

// File: rtl/rtc_paged_regs.sv
// Module: rtc_paged_regs (top)
// Byte-wide paged host window of a real-time clock: registers, counter view,
// alarm compare with interrupt, and save-on-power-fail. Assumes the counter
// chain drives cnt_vec synchronously to clk.
module rtc_paged_regs
    import rtc_bus_pkg::*;
#(
    parameter int NUM_CNT    = 7,
    parameter int PAGE_BYTES = 32,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [NUM_CNT*8-1:0] cnt_vec,
    input  logic                 tick,
    input  logic                 pwr_fail,
    output logic                 irq
);
    logic                 wr_stb, rd_stb, lock_rd, pf_rise;
    logic                 page;
    logic                 alm_match, alm_rise;
    logic [NUM_IRQ-1:0]   irq_mask, flags, clr_vec, set_vec;
    logic [NUM_CNT-1:0]   aen;
    logic [NUM_CNT*8-1:0] alm_vec;

    rtc_host_port i_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .pwr_fail(pwr_fail),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .lock_rd(lock_rd), .pf_rise(pf_rise)
    );

    rtc_regfile #(.NUM_CNT(NUM_CNT), .PAGE_BYTES(PAGE_BYTES)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .lock_rd(lock_rd), .save_stb(pf_rise), .addr(addr), .wdata(wdata),
        .cnt_vec(cnt_vec), .flags(flags), .rdata(rdata), .page(page),
        .irq_mask(irq_mask), .aen(aen), .alm_vec(alm_vec), .clr_vec(clr_vec)
    );

    rtc_alarm_cmp #(.NUM_CNT(NUM_CNT)) i_alarm (
        .clk(clk), .rst_n(rst_n), .cnt_vec(cnt_vec), .alm_vec(alm_vec),
        .aen(aen), .match(alm_match), .match_rise(alm_rise)
    );

    // Interrupt sources in their status bit positions.
    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_TICK]  = tick;
        set_vec[IRQ_ALARM] = alm_rise;
        set_vec[IRQ_PFAIL] = pf_rise;
    end

    rtc_irq_ctrl #(.NUM_IRQ(NUM_IRQ)) i_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask(irq_mask), .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/rtc_paged_regs_chk.sv
// Module: rtc_paged_regs_chk
// Cycle-by-cycle properties of the paged RTC window, bound into the top.
module rtc_paged_regs_chk #(
    parameter int NUM_CNT = 7,
    parameter int ADDR_W  = 5,
    parameter int NUM_IRQ = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs,
    input logic               wr,
    input logic [ADDR_W-1:0]  addr,
    input logic [7:0]         wdata,
    input logic [7:0]         rdata,
    input logic               tick,
    input logic               pwr_fail,
    input logic               irq,
    input logic               page,
    input logic [NUM_IRQ-1:0] flags,
    input logic [NUM_IRQ-1:0] irq_mask,
    input logic [NUM_CNT-1:0] aen,
    input logic               alm_match
);
    logic cs_q;
    logic start;

    // Own copy of the previous select level.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs;
    end
    assign start = cs && !cs_q;

    assert_lock_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr && pwr_fail) |=> (rdata == 8'h00));

    assert_page_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && wr && !pwr_fail && addr == '0) |=> $stable(page));

    assert_tick_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flags[0]);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(start && wr && !pwr_fail && !page && addr == ADDR_W'(1) && wdata[0]))
        |=> flags[0]);

    assert_masked_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    assert_alarm_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aen == '0) |-> !alm_match);
endmodule

bind rtc_paged_regs rtc_paged_regs_chk #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .NUM_IRQ(3)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .pwr_fail(pwr_fail), .irq(irq), .page(page),
    .flags(flags), .irq_mask(irq_mask), .aen(aen), .alm_match(alm_match)
);

// File: tb/test_rtc_paged_regs.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module test_rtc_paged_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NCNT = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs = 1'b0, wr = 1'b0, tick = 1'b0, pwr_fail = 1'b0;
    logic [4:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [NCNT*8-1:0] cnt_vec = '0;
    logic            irq;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_paged_regs i_rtc_paged_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_vec(cnt_vec), .tick(tick), .pwr_fail(pwr_fail), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected byte for each completed read.
    always @(rd_ev) begin
        while (exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); cs = 1; wr = 0; addr = a;
        @(negedge clk); cs = 0;
        exp_q.push_back(exp); tag_q.push_back(tag);
        -> rd_ev;
        #1;
    endtask

    function automatic logic [7:0] cnt_of(input int i);
        return cnt_vec[i*8 +: 8];
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCNT; i++) cnt_vec[i*8 +: 8] = 8'h30 + 8'(i * 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(5'h00, 8'h00, "R1 ctrl");
        bus_read(5'h01, 8'h00, "R1 status");
        bus_read(5'h02, 8'h00, "R1 mask");
        // R3: page 0 RAM, alarm and save bytes
        bus_write(5'h19, 8'hA5); bus_write(5'h1F, 8'h3C);
        bus_write(5'h0B, 8'h11); bus_write(5'h12, 8'h22);
        bus_read(5'h19, 8'hA5, "R3 p0 ram 19");
        bus_read(5'h1F, 8'h3C, "R3 p0 ram 1F");
        bus_read(5'h0B, 8'h11, "R3 alarm byte");
        bus_read(5'h12, 8'h22, "R3 save byte");
        // R2: page select, upper ctrl bits read 0
        bus_write(5'h00, 8'hFD);
        bus_read(5'h00, 8'h01, "R2 ctrl page1");
        bus_write(5'h19, 8'h5A); bus_write(5'h04, 8'h99); bus_write(5'h01, 8'h77);
        bus_read(5'h19, 8'h5A, "R3 p1 ram 19");
        bus_read(5'h04, 8'h99, "R3 p1 ram 04");
        bus_read(5'h01, 8'h77, "R3 p1 ram 01");
        bus_write(5'h00, 8'h00);
        bus_read(5'h00, 8'h00, "R2 ctrl page0");
        bus_read(5'h19, 8'hA5, "R3 page independence");
        // R4: counter view, writes ignored
        bus_write(5'h04, 8'hFF);
        bus_read(5'h04, cnt_of(0), "R4 counter0 after write");
        bus_read(5'h0A, cnt_of(6), "R4 counter6");
        // R4/R5: long access, counter changes mid-cycle
        begin
            logic [7:0] old;
            old = cnt_of(1);
            @(negedge clk); cs = 1; wr = 0; addr = 5'h05;
            @(negedge clk); cnt_vec[15:8] = 8'h77;
            @(negedge clk); @(negedge clk);
            chk("R4 stable during access", rdata, old);
            cs = 0;
            repeat (3) @(negedge clk);
            chk("R5 rdata held", rdata, old);
        end
        bus_read(5'h05, 8'h77, "R4 new counter");
        // R8: tick flag, masked
        @(negedge clk); tick = 1; @(negedge clk); tick = 0;
        bus_read(5'h01, 8'h01, "R8 tick flag");
        chk("R10 irq masked", {7'b0, irq}, 8'h00);
        bus_write(5'h02, 8'h01);
        chk("R10 irq unmasked", {7'b0, irq}, 8'h01);
        // R9: clear, then set wins over clear
        bus_write(5'h01, 8'h01);
        chk("R9 irq after clear", {7'b0, irq}, 8'h00);
        bus_read(5'h01, 8'h00, "R9 cleared");
        @(negedge clk); cs = 1; wr = 1; addr = 5'h01; wdata = 8'h01; tick = 1;
        @(negedge clk); cs = 0; wr = 0; tick = 0;
        bus_read(5'h01, 8'h01, "R9 set wins");
        bus_write(5'h01, 8'h07);
        // R7: alarm on bytes 0 and 2
        bus_write(5'h0B, cnt_of(0)); bus_write(5'h0D, 8'h00);
        bus_write(5'h03, 8'h05);
        bus_read(5'h01, 8'h00, "R7 partial match no flag");
        cnt_vec[23:16] = 8'h00;
        @(negedge clk);
        bus_read(5'h01, 8'h02, "R7 alarm flag");
        chk("R10 alarm irq masked", {7'b0, irq}, 8'h00);
        bus_write(5'h02, 8'h02);
        chk("R10 alarm irq", {7'b0, irq}, 8'h01);
        bus_write(5'h03, 8'h00); bus_write(5'h01, 8'h07); bus_write(5'h02, 8'h00);
        // R11/R6: save on fail, lockout
        bus_write(5'h00, 8'h02);
        bus_read(5'h19, 8'hA5, "R6 pre read");
        @(negedge clk); pwr_fail = 1;
        bus_write(5'h19, 8'h00);
        bus_read(5'h19, 8'h00, "R6 locked read");
        @(negedge clk); pwr_fail = 0;
        bus_read(5'h19, 8'hA5, "R6 write ignored");
        bus_read(5'h01, 8'h04, "R8 power fail flag");
        for (int i = 0; i < NCNT; i++)
            bus_read(5'(8'h12 + i), cnt_of(i), "R11 saved byte");
        begin
            logic [7:0] saved0;
            saved0 = cnt_of(0);
            bus_write(5'h00, 8'h00);
            cnt_vec[7:0] = 8'h44;
            @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
            bus_read(5'h12, saved0, "R11 save disabled");
        end
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule